// File: doc/BRIEF.md
# Load-Store Address Generation Unit

This block sits between the register-read stage and the data-memory port of a 32-bit core. Its inputs are the decoded fields of a load or store: the offset source, the indexing controls, the offset sign, the transfer kind and width, a 12-bit immediate, a shift amount and shift kind, the base register value and the offset register value. From these it produces the byte address sent to memory, the value to write back into the base register and whether that writeback occurs. It also flags an unsupported indexing combination and a word transfer whose address is not 4-byte aligned.

The offset is either a zero-extended immediate or a register value passed through a barrel shifter. The unit adds it to the base or subtracts it from the base. The indexing controls choose one of three modes. In offset mode the address is the sum and the base is left unchanged. In pre-index mode the address is the sum and the base is updated to that sum. In post-index mode the address is the unmodified base and the base is updated to the sum. The datapath is combinational. A parameter adds one output register stage, which is enabled by default.

Top module: `lsagu_top`

## Requirements
- R1: When `off_is_reg` is 0, the offset is `imm_off` zero-extended to 32 bits. `oreg_val`, `shamt` and `shkind` have no effect on any output.
- R2: When `add_sel` is 1 the offset is added to `base_val`; when 0 it is subtracted. The result wraps modulo 2^32. `wb_val` always carries this base±offset result.
- R3: With `pre_sel`=1 and `wb_sel`=0 (offset mode), `mem_addr` is base±offset and `wb_en` is 0.
- R4: With `pre_sel`=1 and `wb_sel`=1 (pre-index mode), `mem_addr` is base±offset and `wb_en` is 1, unless R10 applies. `wb_val` equals `mem_addr`.
- R5: With `pre_sel`=0 and `wb_sel`=0 (post-index mode), `mem_addr` is `base_val` and `wb_en` is 1, unless R10 applies. `wb_val` is base±offset.
- R6: With `pre_sel`=0 and `wb_sel`=1, `illegal` is 1, `wb_en` is 0 and `mem_addr` is `base_val`. In every other combination `illegal` is 0.
- R7: When `off_is_reg` is 1, the offset is `oreg_val` shifted by `shamt`. The shift kind is set by `shkind`: 2'b00 logical left, 2'b01 logical right, 2'b10 arithmetic right. A `shamt` of 0 leaves the value unchanged.
- R8: `shkind` 2'b11 rotates `oreg_val` right by `shamt` over 32 bits. A `shamt` of 0 leaves the value unchanged.
- R9: `is_load` follows `ld_sel` (1 is a load, 0 a store). `is_byte` follows `byte_sel` (1 is a byte transfer, 0 a word transfer).
- R10: For a word transfer (`byte_sel`=0), `misalign` is 1 when `mem_addr[1:0]` is nonzero, and `wb_en` is then 0. A byte transfer never sets `misalign`.
- R11: With `REG_OUT`=1, all outputs appear one clock after the inputs are sampled. A synchronous active-low reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output stage |
| rst_n | input | 1 | Synchronous active-low reset |
| off_is_reg | input | 1 | 1: register offset, 0: immediate offset |
| pre_sel | input | 1 | Indexing control: apply offset before the access |
| add_sel | input | 1 | 1: add offset, 0: subtract offset |
| wb_sel | input | 1 | Indexing control: write-back request |
| ld_sel | input | 1 | 1: load, 0: store |
| byte_sel | input | 1 | 1: byte transfer, 0: word transfer |
| imm_off | input | 12 | Unsigned immediate offset |
| shamt | input | 5 | Shift amount for the register offset |
| shkind | input | 2 | Shift kind for the register offset |
| base_val | input | 32 | Base register value |
| oreg_val | input | 32 | Offset register value |
| mem_addr | output | 32 | Byte address for memory |
| wb_en | output | 1 | Base register writeback enable |
| wb_val | output | 32 | New base value |
| is_load | output | 1 | Load indicator |
| is_byte | output | 1 | Byte-width indicator |
| illegal | output | 1 | Unsupported indexing combination |
| misalign | output | 1 | Word address not 4-byte aligned |

## Verification
The assertions assume that the inputs stay constant from one sampling edge to the next only as far as the registered stage requires. The checker therefore captures its own copy of the indexing controls and the base at the same edge as the output register, and it checks outputs only against that copy. The assertions also assume that `wb_val` always carries base±offset, so an address in an offset or pre-index mode can be compared with `wb_val` without modelling the shifter. The bench changes inputs only on the falling clock edge. It holds each pattern for one full cycle, so every output sampled on the next falling edge comes from exactly one input set.

// File: rtl/lsagu_pkg.sv
// Package for the load-store address generation unit.
// Holds the shift-kind and indexing-mode encodings and the mode decoder.
// Assumes the indexing controls arrive as two separate bits.
package lsagu_pkg;

    typedef enum logic [1:0] {
        SH_LSL = 2'b00,
        SH_LSR = 2'b01,
        SH_ASR = 2'b10,
        SH_ROR = 2'b11
    } shift_e;

    // Encoding is {pre, wb}; the decoder relies on that bit order.
    typedef enum logic [1:0] {
        MODE_POST = 2'b00,
        MODE_BAD  = 2'b01,
        MODE_OFS  = 2'b10,
        MODE_PRE  = 2'b11
    } mode_e;

    localparam int ALIGN_BITS = 2;

    function automatic mode_e mode_of(input logic pre, input logic wb);
        return mode_e'({pre, wb});
    endfunction

endpackage

// File: rtl/lsagu_offset.sv
// Offset former: selects a zero-extended immediate or a shifted register.
// The register path is a logarithmic shifter with one stage per amount bit.
// Assumes DW is a power of two and SH_W = log2(DW).
module lsagu_offset
    import lsagu_pkg::*;
#(
    parameter int DW    = 32,
    parameter int IMM_W = 12,
    parameter int SH_W  = $clog2(DW)
) (
    input  logic             off_is_reg,
    input  logic [IMM_W-1:0] imm_off,
    input  logic [SH_W-1:0]  shamt,
    input  logic [1:0]       shkind,
    input  logic [DW-1:0]    oreg_val,
    output logic [DW-1:0]    offset
);

    localparam int PAD_W = DW - IMM_W;

    logic [DW-1:0] stg [0:SH_W];
    shift_e        kind;

    // Purpose: name the shift kind and feed the first shifter stage.
    always_comb begin
        kind   = shift_e'(shkind);
        stg[0] = oreg_val;
    end

    genvar k;
    generate
        for (k = 0; k < SH_W; k++) begin : g_stage
            localparam int S = 1 << k;
            logic [DW-1:0] moved;

            // Purpose: shift the running value by 2^k in the chosen manner.
            always_comb begin
                unique case (kind)
                    SH_LSL:  moved = {stg[k][DW-S-1:0], {S{1'b0}}};
                    SH_LSR:  moved = {{S{1'b0}}, stg[k][DW-1:S]};
                    SH_ASR:  moved = {{S{stg[k][DW-1]}}, stg[k][DW-1:S]};
                    default: moved = {stg[k][S-1:0], stg[k][DW-1:S]};
                endcase
            end

            // Purpose: pass through or take the shifted value per amount bit.
            always_comb begin
                stg[k+1] = shamt[k] ? moved : stg[k];
            end
        end
    endgenerate

    // Purpose: choose the offset source.
    always_comb begin
        if (off_is_reg)
            offset = stg[SH_W];
        else
            offset = {{PAD_W{1'b0}}, imm_off};
    end

endmodule

// File: rtl/lsagu_addr.sv
// Address and writeback former: adds or subtracts the offset, picks the
// access address from the indexing mode, and raises the illegal and
// misalign flags. A flagged access never writes back.
// Assumes byte addressing with 4-byte words.
module lsagu_addr
    import lsagu_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          pre_sel,
    input  logic          wb_sel,
    input  logic          add_sel,
    input  logic          byte_sel,
    input  logic [DW-1:0] base_val,
    input  logic [DW-1:0] offset,
    output logic [DW-1:0] addr,
    output logic [DW-1:0] new_base,
    output logic          wb_en,
    output logic          bad_mode,
    output logic          mis
);

    mode_e         mode;
    logic [DW-1:0] sum;
    logic          want_wb;

    // Purpose: form base plus or minus offset.
    always_comb begin
        sum = add_sel ? (base_val + offset) : (base_val - offset);
    end

    // Purpose: decode indexing mode into address choice and writeback wish.
    always_comb begin
        mode = mode_of(pre_sel, wb_sel);
        unique case (mode)
            MODE_OFS: begin addr = sum;      want_wb = 1'b0; bad_mode = 1'b0; end
            MODE_PRE: begin addr = sum;      want_wb = 1'b1; bad_mode = 1'b0; end
            MODE_POST: begin addr = base_val; want_wb = 1'b1; bad_mode = 1'b0; end
            default: begin addr = base_val; want_wb = 1'b0; bad_mode = 1'b1; end
        endcase
    end

    // Purpose: flag unaligned words and gate writeback on any fault.
    always_comb begin
        mis      = !byte_sel && (addr[ALIGN_BITS-1:0] != '0);
        wb_en    = want_wb && !mis && !bad_mode;
        new_base = sum;
    end

endmodule

// File: rtl/lsagu_outreg.sv
// Optional output stage. With REG_OUT=1 the bundle is registered with a
// synchronous active-low reset to zero; with REG_OUT=0 it is a wire.
module lsagu_outreg #(
    parameter int W       = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        if (REG_OUT) begin : g_reg
            // Purpose: hold the result for one cycle, clear on reset.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= '0;
                else
                    q <= d;
            end
        end else begin : g_wire
            // Purpose: pass the result straight through.
            always_comb q = d;
        end
    endgenerate

endmodule

// File: rtl/lsagu_top.sv
// Load-store address generation unit, top level.
// Joins the offset former, the address former and the output stage.
// Assumes the decoded fields and register values are valid together.
module lsagu_top #(
    parameter int DW      = 32,
    parameter int IMM_W   = 12,
    parameter int SH_W    = $clog2(DW),
    parameter bit REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             off_is_reg,
    input  logic             pre_sel,
    input  logic             add_sel,
    input  logic             wb_sel,
    input  logic             ld_sel,
    input  logic             byte_sel,
    input  logic [IMM_W-1:0] imm_off,
    input  logic [SH_W-1:0]  shamt,
    input  logic [1:0]       shkind,
    input  logic [DW-1:0]    base_val,
    input  logic [DW-1:0]    oreg_val,
    output logic [DW-1:0]    mem_addr,
    output logic             wb_en,
    output logic [DW-1:0]    wb_val,
    output logic             is_load,
    output logic             is_byte,
    output logic             illegal,
    output logic             misalign
);

    localparam int BUS_W = 2 * DW + 5;

    logic [DW-1:0]    offset;
    logic [DW-1:0]    c_addr;
    logic [DW-1:0]    c_base;
    logic             c_wb;
    logic             c_bad;
    logic             c_mis;
    logic [BUS_W-1:0] bus_d;
    logic [BUS_W-1:0] bus_q;

    lsagu_offset #(.DW(DW), .IMM_W(IMM_W), .SH_W(SH_W)) u_off (
        .off_is_reg (off_is_reg),
        .imm_off    (imm_off),
        .shamt      (shamt),
        .shkind     (shkind),
        .oreg_val   (oreg_val),
        .offset     (offset)
    );

    lsagu_addr #(.DW(DW)) u_addr (
        .pre_sel  (pre_sel),
        .wb_sel   (wb_sel),
        .add_sel  (add_sel),
        .byte_sel (byte_sel),
        .base_val (base_val),
        .offset   (offset),
        .addr     (c_addr),
        .new_base (c_base),
        .wb_en    (c_wb),
        .bad_mode (c_bad),
        .mis      (c_mis)
    );

    // Purpose: pack the combinational result for the output stage.
    always_comb begin
        bus_d = {c_addr, c_base, c_wb, ld_sel, byte_sel, c_bad, c_mis};
    end

    lsagu_outreg #(.W(BUS_W), .REG_OUT(REG_OUT)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (bus_d),
        .q     (bus_q)
    );

    // Purpose: unpack the stage output onto the ports.
    always_comb begin
        {mem_addr, wb_val, wb_en, is_load, is_byte, illegal, misalign} = bus_q;
    end

endmodule

// File: rtl/lsagu_checker.sv
// Property checker for lsagu_top, bound to every instance.
// Keeps its own copy of the indexing controls and base, aligned to the
// output latency, and checks outputs against that copy.
module lsagu_checker #(
    parameter int DW      = 32,
    parameter bit REG_OUT = 1'b1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pre_sel,
    input logic          wb_sel,
    input logic          byte_sel,
    input logic [DW-1:0] base_val,
    input logic [DW-1:0] mem_addr,
    input logic          wb_en,
    input logic [DW-1:0] wb_val,
    input logic          is_byte,
    input logic          illegal,
    input logic          misalign
);

    logic          d_pre;
    logic          d_wb;
    logic          d_valid;
    logic [DW-1:0] d_base;

    generate
        if (REG_OUT) begin : g_dly
            // Purpose: capture controls at the same edge as the outputs.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    d_pre <= 1'b0; d_wb <= 1'b0; d_base <= '0; d_valid <= 1'b0;
                end else begin
                    d_pre <= pre_sel; d_wb <= wb_sel; d_base <= base_val; d_valid <= 1'b1;
                end
            end
        end else begin : g_nodly
            // Purpose: use the live controls when the output is combinational.
            always_comb begin
                d_pre = pre_sel; d_wb = wb_sel; d_base = base_val; d_valid = rst_n;
            end
        end
    endgenerate

    AST_OFS_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (d_valid && d_pre && !d_wb) |-> !wb_en);                                   // R3
    AST_SUM_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (d_valid && d_pre) |-> (mem_addr == wb_val));                              // R4
    AST_PRE_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (d_valid && d_pre && d_wb && !misalign) |-> wb_en);                        // R4
    AST_POST_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (d_valid && !d_pre) |-> (mem_addr == d_base));                             // R5
    AST_BAD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        d_valid |-> (illegal == (!d_pre && d_wb)));                                // R6
    AST_WB_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (!illegal && !misalign));                                        // R10
    AST_MIS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> (!is_byte && (mem_addr[1:0] != 2'b00)));                     // R10
    AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (d_valid && !is_byte && (mem_addr[1:0] != 2'b00)) |-> misalign);           // R10

endmodule

bind lsagu_top lsagu_checker #(.DW(DW), .REG_OUT(REG_OUT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pre_sel  (pre_sel),
    .wb_sel   (wb_sel),
    .byte_sel (byte_sel),
    .base_val (base_val),
    .mem_addr (mem_addr),
    .wb_en    (wb_en),
    .wb_val   (wb_val),
    .is_byte  (is_byte),
    .illegal  (illegal),
    .misalign (misalign)
);

// File: tb/tb_lsagu_top.sv
// Directed bench for lsagu_top: one task per scenario, explicit expectations.
module tb_lsagu_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        off_is_reg = 1'b0, pre_sel = 1'b0, add_sel = 1'b0, wb_sel = 1'b0;
    logic        ld_sel = 1'b0, byte_sel = 1'b0;
    logic [11:0] imm_off = '0;
    logic [4:0]  shamt = '0;
    logic [1:0]  shkind = '0;
    logic [31:0] base_val = '0, oreg_val = '0;
    logic [31:0] mem_addr, wb_val;
    logic        wb_en, is_load, is_byte, illegal, misalign;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    lsagu_top dut (
        .clk(clk), .rst_n(rst_n), .off_is_reg(off_is_reg), .pre_sel(pre_sel),
        .add_sel(add_sel), .wb_sel(wb_sel), .ld_sel(ld_sel), .byte_sel(byte_sel),
        .imm_off(imm_off), .shamt(shamt), .shkind(shkind), .base_val(base_val),
        .oreg_val(oreg_val), .mem_addr(mem_addr), .wb_en(wb_en), .wb_val(wb_val),
        .is_load(is_load), .is_byte(is_byte), .illegal(illegal), .misalign(misalign)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, act, exp);
        end
    endtask

    // Drive one pattern on a falling edge, sample after the next rising edge.
    task automatic run(string req, logic reg_o, logic pre, logic add, logic wb,
                       logic ld, logic byt, logic [11:0] imm, logic [4:0] sa,
                       logic [1:0] sk, logic [31:0] base, logic [31:0] oreg,
                       logic [31:0] e_addr, logic e_wb, logic [31:0] e_val,
                       logic e_ill, logic e_mis);
        @(negedge clk);
        off_is_reg = reg_o; pre_sel = pre; add_sel = add; wb_sel = wb;
        ld_sel = ld; byte_sel = byt; imm_off = imm; shamt = sa; shkind = sk;
        base_val = base; oreg_val = oreg;
        @(negedge clk);
        chk(req, "mem_addr", mem_addr, e_addr);
        chk(req, "wb_en", 32'(wb_en), 32'(e_wb));
        chk(req, "wb_val", wb_val, e_val);
        chk(req, "illegal", 32'(illegal), 32'(e_ill));
        chk(req, "misalign", 32'(misalign), 32'(e_mis));
        chk("R9", "is_load", 32'(is_load), 32'(ld));
        chk("R9", "is_byte", 32'(is_byte), 32'(byt));
    endtask

    task automatic t_reset_r11;
        @(negedge clk);
        ld_sel = 1'b1; byte_sel = 1'b1; base_val = 32'h1234_5678; pre_sel = 1'b0;
        @(negedge clk);
        chk("R11", "rst mem_addr", mem_addr, 32'h0);
        chk("R11", "rst wb_val", wb_val, 32'h0);
        chk("R11", "rst flags", {27'h0, wb_en, is_load, is_byte, illegal, misalign}, 32'h0);
        rst_n = 1'b1;
    endtask

    task automatic t_imm_r1_r2_r3;
        run("R3", 0, 1, 1, 0, 1, 0, 12'hFFC, 0, 0, 32'h1000, 0, 32'h1FFC, 0, 32'h1FFC, 0, 0);
        run("R2", 0, 1, 0, 0, 0, 0, 12'h010, 0, 0, 32'h1000, 0, 32'h0FF0, 0, 32'h0FF0, 0, 0);
        run("R2", 0, 1, 0, 0, 1, 0, 12'h008, 0, 0, 32'h4, 0, 32'hFFFF_FFFC, 0, 32'hFFFF_FFFC, 0, 0);
        // R1: register, amount and kind must not matter with an immediate offset
        run("R1", 0, 1, 1, 0, 1, 0, 12'h004, 5'd7, 2'b11, 32'h100, 32'hFFFF_FFFF,
            32'h104, 0, 32'h104, 0, 0);
    endtask

    task automatic t_modes_r4_r5_r6;
        run("R4", 0, 1, 1, 1, 0, 0, 12'h008, 0, 0, 32'h2000, 0, 32'h2008, 1, 32'h2008, 0, 0);
        run("R5", 0, 0, 0, 0, 1, 0, 12'd26, 0, 0, 32'h3000, 0, 32'h3000, 1, 32'h2FE6, 0, 0);
        run("R6", 0, 0, 1, 1, 1, 0, 12'h004, 0, 0, 32'h4000, 0, 32'h4000, 0, 32'h4004, 1, 0);
    endtask

    task automatic t_shift_r7;
        run("R7", 1, 1, 1, 0, 1, 0, 0, 5'd2, 2'b00, 32'h100, 32'h3, 32'h10C, 0, 32'h10C, 0, 0);
        run("R7", 1, 1, 0, 0, 1, 0, 0, 5'd4, 2'b01, 32'h100, 32'h80, 32'hF8, 0, 32'hF8, 0, 0);
        run("R7", 1, 1, 1, 0, 1, 0, 0, 5'd4, 2'b10, 32'h100, 32'hFFFF_FF00, 32'hF0, 0, 32'hF0, 0, 0);
        run("R7", 1, 1, 1, 0, 1, 0, 0, 5'd0, 2'b01, 32'h0, 32'h40, 32'h40, 0, 32'h40, 0, 0);
        run("R7", 1, 1, 1, 0, 1, 1, 0, 5'd31, 2'b00, 32'h0, 32'h1, 32'h8000_0000, 0, 32'h8000_0000, 0, 0);
    endtask

    task automatic t_rotate_r8;
        run("R8", 1, 1, 1, 0, 1, 0, 0, 5'd2, 2'b11, 32'h10, 32'h3, 32'hC000_0010, 0, 32'hC000_0010, 0, 0);
        run("R8", 1, 1, 1, 0, 1, 0, 0, 5'd0, 2'b11, 32'h0, 32'h24, 32'h24, 0, 32'h24, 0, 0);
    endtask

    task automatic t_align_r10;
        run("R10", 0, 1, 1, 1, 1, 0, 0, 0, 0, 32'h1001, 0, 32'h1001, 0, 32'h1001, 0, 1);
        run("R10", 0, 1, 1, 1, 1, 1, 0, 0, 0, 32'h1001, 0, 32'h1001, 1, 32'h1001, 0, 0);
        run("R10", 0, 0, 1, 0, 0, 0, 12'h004, 0, 0, 32'h1002, 0, 32'h1002, 0, 32'h1006, 0, 1);
    endtask

    initial begin
        t_reset_r11;
        t_imm_r1_r2_r3;
        t_modes_r4_r5_r6;
        t_shift_r7;
        t_rotate_r8;
        t_align_r10;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule